// File: doc/BRIEF.md
# Oversampled Async Receiver with Break

This block takes a single start/stop framed serial line and turns it into parallel data words. A 16x bit-rate enable (`tick_i`) is supplied from outside. Each received frame loses its start and stop bits, and the data word goes into a four-entry queue. A downstream synchronous transmitter drains that queue through a show-ahead read port. A frame carries 8 or 9 data bits, chosen by `len9_i`.

Some low pulses are too short to reach the centre of a start bit. These are rejected as false starts and never begin a frame. The line may also stay low for eleven or more bit periods. The block then raises `break_o` and holds it until the line is seen high again, so the transmitter can code the condition for the far end.

`ready_o` is a status output that a local port can use as a clear-to-send. It drops once two or more words are queued, not only when the queue is full. While the active-low reset is asserted, the queue is cleared, the line is treated as idle high, and `ready_o` is held low. `rxd_i` is expected to be synchronous to `clk_i`.

Top module: `async_rx_break`

## Requirements
- R1: While `rst_ni` is low, `rd_valid_o`, `ready_o` and `break_o` are all 0.
- R2: An idle receiver begins a frame on the first `tick_i` cycle that samples `rxd_i` low. It samples again on the 8th following tick. If the line is high there, the frame is abandoned and no word is written.
- R3: Data bits are sampled every 16 ticks after the start check, least significant bit first. When `len9_i`=1, 9 bits are taken. When `len9_i`=0, 8 bits are taken and bit 8 of the stored word is 0.
- R4: The stop bit is sampled 16 ticks after the last data bit. If it is high, the word enters the queue on that same clock edge.
- R5: If the stop bit samples low, the word is discarded. The receiver then ignores the line until a tick samples it high.
- R6: `break_o` rises on the edge of the 176th consecutive low tick sample (11 bit periods). It stays high until a tick samples `rxd_i` high, and clears on that edge.
- R7: The queue holds up to 4 words, oldest first. `rd_valid_o`=1 whenever it is non-empty, and `rd_data_o` then shows the oldest word. A cycle with `rd_en_i` and `rd_valid_o` both high removes that word.
- R8: A word that completes while 4 words are held is dropped, even if a read happens on the same edge.
- R9: Out of reset, `ready_o` is 0 when 2 or more words are held and 1 otherwise.
- R10: `rd_en_i` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 16x bit-rate sampling enable |
| rxd_i | input | 1 | Serial line, idle high |
| len9_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| rd_en_i | input | 1 | Pop the oldest queued word |
| rd_data_o | output | 9 | Oldest queued word |
| rd_valid_o | output | 1 | Queue non-empty |
| ready_o | output | 1 | High while fewer than 2 words queued |
| break_o | output | 1 | Line break detected |

## Verification
The line is driven with several kinds of stimulus:
- clean 8-bit and 9-bit frames with mixed bit patterns, which separate LSB-first ordering from reversed order and catch loss of the ninth bit;
- short low glitches, which separate a centre-confirmed start from an edge-triggered one;
- frames with a low stop bit followed by a good frame, which show that the word is discarded and that framing recovers;
- a burst of five back-to-back frames with no reads, which distinguishes the two-word status threshold from a full flag and shows that the fifth word is dropped;
- a long low interval, whose break flag is checked both short of and past the 176-tick threshold and again after the line returns high.

A behavioural model that counts ticks from the start edge is compared against the ports on every clock.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/rx_framer.sv
module rx_framer import async_rx_pkg::*; #(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  logic                len9_i,
  output logic                wr_o,
  output logic [MAX_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OSR - 1);

  rx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_idx;
  logic [MAX_BITS-1:0] word_q;

  assign last_idx = len9_i ? IDX_W'(MAX_BITS-1) : IDX_W'(MAX_BITS-2);
  assign wr_o     = tick_i && (state_q == ST_STOP) && (cnt_q == CNT_FULL) && rxd_i;
  assign word_o   = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (!rxd_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_q <= '0;
            if (rxd_i) state_q <= ST_IDLE;   // false start
            else begin
              state_q <= ST_DATA;
              idx_q   <= '0;
              word_q  <= '0;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (cnt_q == CNT_FULL) begin
            cnt_q         <= '0;
            word_q[idx_q] <= rxd_i;
            if (idx_q == last_idx) state_q <= ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            state_q <= rxd_i ? ST_IDLE : ST_WAIT_HI;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT_HI: if (rxd_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
  parameter int OSR        = 16,
  parameter int BREAK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  output logic brk_o
);
  localparam int THR   = OSR * BREAK_BITS;
  localparam int CNT_W = $clog2(THR + 1);
  localparam logic [CNT_W-1:0] THR_C  = CNT_W'(THR);
  localparam logic [CNT_W-1:0] THR_M1 = CNT_W'(THR - 1);

  logic [CNT_W-1:0] low_q;
  logic             brk_q;

  assign brk_o = brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      brk_q <= 1'b0;
    end else if (tick_i) begin
      if (rxd_i) begin
        low_q <= '0;
        brk_q <= 1'b0;
      end else begin
        if (low_q < THR_C) low_q <= low_q + 1'b1;
        if (low_q >= THR_M1) brk_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              rd_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [FILL_W-1:0] fill_o
);
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

  logic [WIDTH-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [FILL_W-1:0] fill_q;
  logic              push, pop;

  assign push    = wr_i && (fill_q != FILL_MAX);
  assign pop     = rd_i && (fill_q != '0);
  assign rdata_o = mem_q[rp_q];
  assign fill_o  = fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      if (push && !pop)      fill_q <= fill_q + 1'b1;
      else if (pop && !push) fill_q <= fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/async_rx_break.sv
module async_rx_break #(
  parameter int OSR        = 16,
  parameter int MAX_BITS   = 9,
  parameter int BREAK_BITS = 11,
  parameter int DEPTH      = 4,
  parameter int NEAR_FULL  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  logic                len9_i,
  input  logic                rd_en_i,
  output logic [MAX_BITS-1:0] rd_data_o,
  output logic                rd_valid_o,
  output logic                ready_o,
  output logic                break_o
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] NEAR_C = FILL_W'(NEAR_FULL);

  logic                wr_en;
  logic [MAX_BITS-1:0] wr_word;
  logic [FILL_W-1:0]   fill;

  rx_framer #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_framer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rxd_i (rxd_i),
    .len9_i(len9_i),
    .wr_o  (wr_en),
    .word_o(wr_word)
  );

  rx_break_det #(.OSR(OSR), .BREAK_BITS(BREAK_BITS)) u_break (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rxd_i (rxd_i),
    .brk_o (break_o)
  );

  rx_fifo #(.WIDTH(MAX_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en),
    .wdata_i(wr_word),
    .rd_i   (rd_en_i),
    .rdata_o(rd_data_o),
    .fill_o (fill)
  );

  assign rd_valid_o = (fill != '0);
  assign ready_o    = rst_ni && (fill < NEAR_C);
endmodule

// File: rtl/async_rx_break_chk.sv
module async_rx_break_chk #(
  parameter int DEPTH  = 4,
  parameter int FILL_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rxd_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic              ready_o,
  input logic              break_o,
  input logic              wr_en,
  input logic [FILL_W-1:0] fill
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_OUTPUTS: assert (!ready_o && !rd_valid_o); // R1
    end
  end

  AST_WRITE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_en |-> tick_i); // R4
  AST_BREAK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) break_o && !(tick_i && rxd_i) |=> break_o); // R6
  AST_BREAK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) tick_i && rxd_i |=> !break_o); // R6
  AST_POP_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(rd_valid_o) |-> $past(rd_en_i)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) fill <= FILL_W'(DEPTH)); // R8
  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_valid_o |-> ready_o); // R9
endmodule

bind async_rx_break async_rx_break_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rxd_i     (rxd_i),
  .rd_en_i   (rd_en_i),
  .rd_valid_o(rd_valid_o),
  .ready_o   (ready_o),
  .break_o   (break_o),
  .wr_en     (wr_en),
  .fill      (fill)
);

// File: tb/async_rx_break_tb_top.sv
`timescale 1ns/1ps
module async_rx_break_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       len9 = 1'b0;
  logic       rd_en = 1'b0;
  logic [8:0] rd_data;
  logic       rd_valid, ready, brk;

  int checks = 0;
  int errors = 0;
  int div = 0;

  always #10 clk = ~clk;  // 50 MHz

  async_rx_break dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .len9_i(len9),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .ready_o(ready), .break_o(brk)
  );

  // 16x enable: one clock in four
  always @(negedge clk) begin
    div  = (div + 1) % 4;
    tick = (div == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: tick count since start edge, sample points computed
  int         m_mode = 0;  // 0 idle, 1 in frame, 2 wait for high
  int         m_t = 0;
  int         m_low = 0;
  bit         m_brk = 1'b0;
  logic [8:0] m_word = '0;
  logic [8:0] q[$];

  always @(posedge clk) begin
    int  sz, nb, k;
    bit  push;
    push = 1'b0;
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_low = 0; m_brk = 1'b0; m_word = '0;
      q.delete();
    end else begin
      if (tick) begin
        if (rxd) begin m_low = 0; m_brk = 1'b0; end
        else begin m_low++; if (m_low >= 176) m_brk = 1'b1; end
        case (m_mode)
          0: if (!rxd) begin m_mode = 1; m_t = 0; m_word = '0; end
          1: begin
            m_t++;
            nb = len9 ? 9 : 8;
            if (m_t == 8) begin
              if (rxd) m_mode = 0;
            end else if (m_t > 8 && ((m_t - 8) % 16) == 0) begin
              k = (m_t - 8) / 16 - 1;
              if (k < nb) m_word[k] = rxd;
              else begin
                push   = rxd;
                m_mode = rxd ? 0 : 2;
              end
            end
          end
          default: if (rxd) m_mode = 0;
        endcase
      end
      sz = q.size();
      if (rd_en && sz > 0) void'(q.pop_front());
      if (push && sz < 4) q.push_back(m_word);
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      check(!rd_valid && !ready && !brk, "R1 reset outputs", {rd_valid, ready, brk}, 0);
    end else begin
      check(rd_valid == (q.size() != 0), "R7 rd_valid", rd_valid, q.size() != 0);
      if (q.size() != 0) check(rd_data == q[0], "R7 rd_data", rd_data, q[0]);
      check(ready == (q.size() < 2), "R9 ready", ready, q.size() < 2);
      check(brk == m_brk, "R6 break", brk, m_brk);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input bit stop_lvl);
    rxd = 1'b0; wait_clk(64);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clk(64); end
    rxd = stop_lvl; wait_clk(64);
    rxd = 1'b1; wait_clk(64);
  endtask

  task automatic pop_check(input logic [8:0] exp, input string tag);
    @(negedge clk); #3;
    check(rd_valid && rd_data == exp, tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk); #3;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    #3;
    check(!rd_valid && !ready && !brk, "R1 directed reset", {rd_valid, ready, brk}, 0);
    rst_n = 1'b1;
    wait_clk(20);

    // R3/R4: 8-bit frame, LSB first
    send_frame(9'h0A5, 8, 1'b1);
    pop_check(9'h0A5, "R3 8-bit word");
    // R3: 9-bit frame
    len9 = 1'b1;
    send_frame(9'h1C3, 9, 1'b1);
    pop_check(9'h1C3, "R3 9-bit word");
    len9 = 1'b0;

    // R2: short low glitch
    rxd = 1'b0; wait_clk(20); rxd = 1'b1; wait_clk(200);
    #3; check(!rd_valid, "R2 false start", rd_valid, 0);

    // R5: stop bit low, then recovery
    send_frame(9'h0F0, 8, 1'b0);
    #3; check(!rd_valid, "R5 framing error discards", rd_valid, 0);
    send_frame(9'h03C, 8, 1'b1);
    pop_check(9'h03C, "R5 recovery after framing error");

    // R9/R8: fill with five frames
    send_frame(9'h011, 8, 1'b1);
    #3; check(ready, "R9 ready with one word", ready, 1);
    send_frame(9'h022, 8, 1'b1);
    #3; check(!ready, "R9 not ready with two words", ready, 0);
    send_frame(9'h033, 8, 1'b1);
    send_frame(9'h044, 8, 1'b1);
    send_frame(9'h055, 8, 1'b1);
    pop_check(9'h011, "R8 first kept");
    pop_check(9'h022, "R8 second kept");
    pop_check(9'h033, "R8 third kept");
    #3; check(ready, "R9 ready again", ready, 1);
    pop_check(9'h044, "R8 fourth kept");
    #3; check(!rd_valid, "R8 fifth dropped", rd_valid, 0);

    // R10: read when empty
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    #3; check(!rd_valid && ready, "R10 empty read", {rd_valid, ready}, 1);
    send_frame(9'h05A, 8, 1'b1);
    pop_check(9'h05A, "R10 queue intact after empty read");

    // R6: break
    rxd = 1'b0; wait_clk(680);
    #3; check(!brk, "R6 no break before threshold", brk, 0);
    wait_clk(120);
    #3; check(brk, "R6 break after threshold", brk, 1);
    check(!rd_valid, "R5 no word during break", rd_valid, 0);
    rxd = 1'b1; wait_clk(12);
    #3; check(!brk, "R6 break clears on high", brk, 0);
    wait_clk(100);
    send_frame(9'h081, 8, 1'b1);
    pop_check(9'h081, "R5 receive after break");

    wait_clk(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule